// File: doc/BRIEF.md
# PCI Bus Parity Generator

This block produces the parity bit for a 32-bit PCI agent that can act either as the initiator or as the target of a transaction. It watches the multiplexed address/data lines, the command/byte-enable lines, the cycle frame, both ready handshakes, and two status inputs from its own bus interface: the current role (initiator or target) and the transfer direction (write or read). On each phase where this agent is the one driving the address/data lines, it computes even parity over all 36 bits and presents it, with an output enable, on the following clock.

Ownership follows the PCI turnaround rules. As initiator, the agent owns the address phase and the data phases of writes. As target, it owns the data phases of reads. A data phase counts only when it completes, meaning both ready signals are sampled low on the same edge. Wait-state clocks produce no parity. The output enable is high for exactly one clock per owned phase, and it is low after reset. The physical tri-state pad, parity checking and error reporting sit outside this block.

Top module: `pci_par_gen`

## Requirements
- R1: A synchronous active-high reset makes `par_oe_o` and `par_o` 0 on the next clock, and this holds even if a phase completes on that same edge.
- R2: When `par_oe_o` is 1, `par_o` equals the XOR of the 32 `ad_i` bits and the 4 `cbe_n_i` bits sampled on the previous rising edge, so the 37 bits together hold an even number of ones.
- R3: An address phase is a rising edge where `frame_n_i` is 0 and was 1 on the previous edge. When `is_master_i` is 1, an address phase gives `par_oe_o` = 1 on the next clock.
- R4: A completed data phase is an edge where both `irdy_n_i` and `trdy_n_i` are 0. With `is_master_i` = 1 and `is_write_i` = 1, a completed data phase gives `par_oe_o` = 1 on the next clock.
- R5: With `is_master_i` = 0 and `is_write_i` = 0 (target read), a completed data phase gives `par_oe_o` = 1 on the next clock.
- R6: A completed data phase of an initiator read (`is_master_i`=1, `is_write_i`=0) or of a target write (`is_master_i`=0, `is_write_i`=1) leaves `par_oe_o` at 0 on the next clock.
- R7: A clock where `frame_n_i` stays low but either ready signal is 1 (a wait state) gives `par_oe_o` = 0 on the next clock.
- R8: Back-to-back completed phases give `par_oe_o` = 1 on consecutive clocks, and each clock carries the parity of its own phase.
- R9: An address phase seen while `is_master_i` = 0 gives `par_oe_o` = 0 on the next clock.
- R10: `par_o` is 0 whenever `par_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ad_i | input | 32 | Address/data lines as seen on the bus |
| cbe_n_i | input | 4 | Command/byte-enable lines, active low |
| frame_n_i | input | 1 | Cycle frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| is_master_i | input | 1 | 1 when this agent is the initiator of the current transaction |
| is_write_i | input | 1 | 1 when the current transaction is a write |
| par_o | output | 1 | Registered parity bit |
| par_oe_o | output | 1 | Registered output enable for the parity pad |

## Verification
Several properties are checked on every clock. The parity relation to the previous edge's bus values is checked, and so is the zero level of `par_o` while disabled. The checker also enables after every owned address or data completion and stays silent after every foreign completion or wait state. The bench scenarios cover the rest, which no single property captures. These include full transaction sequences of each role and direction, back-to-back phases with changing data, all-ones and sparse parity corners, and a reset that lands on a completing edge.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  // Classification of the current bus clock as seen by this agent.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

endpackage

// File: rtl/pci_par_tree.sv
// Even parity over the address/data and command/byte-enable lines, built
// as one partial per byte lane followed by a final reduction.
module pci_par_tree #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe_n,
  output logic             par
);
  localparam int LANE_W = AD_W / CBE_W;

  logic [CBE_W-1:0] lane_par;

  genvar g;
  generate
    for (g = 0; g < CBE_W; g++) begin : g_lane
      assign lane_par[g] = (^ad[g*LANE_W +: LANE_W]) ^ cbe_n[g];
    end
  endgenerate

  assign par = ^lane_par;
endmodule

// File: rtl/pci_par_phase.sv
// Sorts each bus clock into address phase, completed data phase or neither.
module pci_par_phase
  import pci_par_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   frame_n,
  input  logic   irdy_n,
  input  logic   trdy_n,
  output phase_e phase
);
  logic frame_n_q;

  always_ff @(posedge clk) begin
    if (rst) frame_n_q <= 1'b1;
    else     frame_n_q <= frame_n;
  end

  always_comb begin
    if (!frame_n && frame_n_q)  phase = PH_ADDR;
    else if (!irdy_n && !trdy_n) phase = PH_DATA;
    else                         phase = PH_IDLE;
  end
endmodule

// File: rtl/pci_par_own.sv
// Decides whether this agent drove the address/data lines in a phase.
module pci_par_own
  import pci_par_pkg::*;
(
  input  phase_e phase,
  input  logic   is_master,
  input  logic   is_write,
  output logic   drive
);
  always_comb begin
    unique case (phase)
      PH_ADDR: drive = is_master;
      PH_DATA: drive = (is_master == is_write);
      default: drive = 1'b0;
    endcase
  end
endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic             trdy_n_i,
  input  logic             is_master_i,
  input  logic             is_write_i,
  output logic             par_o,
  output logic             par_oe_o
);
  phase_e phase;
  logic   drive;
  logic   par_now;

  pci_par_tree #(.AD_W(AD_W), .CBE_W(CBE_W)) u_tree (
    .ad    (ad_i),
    .cbe_n (cbe_n_i),
    .par   (par_now)
  );

  pci_par_phase u_phase (
    .clk     (clk),
    .rst     (rst),
    .frame_n (frame_n_i),
    .irdy_n  (irdy_n_i),
    .trdy_n  (trdy_n_i),
    .phase   (phase)
  );

  pci_par_own u_own (
    .phase     (phase),
    .is_master (is_master_i),
    .is_write  (is_write_i),
    .drive     (drive)
  );

  // Registered outputs: parity of the owning phase, one clock late.
  always_ff @(posedge clk) begin
    if (rst) begin
      par_oe_o <= 1'b0;
      par_o    <= 1'b0;
    end else begin
      par_oe_o <= drive;
      par_o    <= drive & par_now;
    end
  end
endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [AD_W-1:0]  ad_i,
  input logic [CBE_W-1:0] cbe_n_i,
  input logic             frame_n_i,
  input logic             irdy_n_i,
  input logic             trdy_n_i,
  input logic             is_master_i,
  input logic             is_write_i,
  input logic             par_o,
  input logic             par_oe_o
);
  logic frame_prev;
  always_ff @(posedge clk) begin
    if (rst) frame_prev <= 1'b1;
    else     frame_prev <= frame_n_i;
  end

  logic start_now, done_now;
  assign start_now = !frame_n_i && frame_prev;
  assign done_now  = !irdy_n_i && !trdy_n_i;

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!par_oe_o && !par_o));

  // R2
  a_r2_even_parity: assert property (@(posedge clk) disable iff (rst)
    par_oe_o |-> (par_o == ^$past({ad_i, cbe_n_i})));

  // R3
  a_r3_master_addr: assert property (@(posedge clk) disable iff (rst)
    (start_now && is_master_i) |=> par_oe_o);

  // R4
  a_r4_master_write: assert property (@(posedge clk) disable iff (rst)
    (done_now && is_master_i && is_write_i) |=> par_oe_o);

  // R5
  a_r5_target_read: assert property (@(posedge clk) disable iff (rst)
    (done_now && !is_master_i && !is_write_i) |=> par_oe_o);

  // R6
  a_r6_foreign_data: assert property (@(posedge clk) disable iff (rst)
    (done_now && !start_now && (is_master_i != is_write_i)) |=> !par_oe_o);

  // R7
  a_r7_wait_state: assert property (@(posedge clk) disable iff (rst)
    (!start_now && !done_now) |=> !par_oe_o);

  // R9
  a_r9_target_addr: assert property (@(posedge clk) disable iff (rst)
    (start_now && !done_now && !is_master_i) |=> !par_oe_o);

  // R10
  a_r10_idle_low: assert property (@(posedge clk) disable iff (rst)
    !par_oe_o |-> !par_o);
endmodule

bind pci_par_gen pci_par_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .ad_i        (ad_i),
  .cbe_n_i     (cbe_n_i),
  .frame_n_i   (frame_n_i),
  .irdy_n_i    (irdy_n_i),
  .trdy_n_i    (trdy_n_i),
  .is_master_i (is_master_i),
  .is_write_i  (is_write_i),
  .par_o       (par_o),
  .par_oe_o    (par_oe_o)
);

// File: tb/test_pci_par_gen.sv
`timescale 1ns/1ps
module test_pci_par_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic        is_master = 1'b0, is_write = 1'b0;
  logic        par, par_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pci_par_gen i_pci_par_gen (
    .clk(clk), .rst(rst), .ad_i(ad), .cbe_n_i(cbe_n),
    .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
    .is_master_i(is_master), .is_write_i(is_write),
    .par_o(par), .par_oe_o(par_oe)
  );

  // Row: {master, write, frame_n, irdy_n, trdy_n, exp_oe, ad[31:0], cbe_n[3:0]}
  localparam int N = 18;
  localparam logic [41:0] TBL [0:N-1] = '{
    {6'b11_111_0, 32'h0000_0000, 4'hF},  // 0 idle
    {6'b11_011_1, 32'h1234_5678, 4'h7},  // 1 master write address
    {6'b11_001_0, 32'hAAAA_0001, 4'h0},  // 2 target wait
    {6'b11_000_1, 32'hAAAA_0001, 4'h0},  // 3 write data done
    {6'b11_100_1, 32'h0F0F_F0F0, 4'h3},  // 4 last write data, back to back
    {6'b11_111_0, 32'h0000_0000, 4'hF},  // 5 idle
    {6'b10_011_1, 32'h8000_0003, 4'h6},  // 6 master read address
    {6'b10_001_0, 32'h0000_0000, 4'h0},  // 7 turnaround
    {6'b10_100_0, 32'hDEAD_BEEF, 4'h0},  // 8 master read data done
    {6'b10_111_0, 32'h0000_0000, 4'hF},  // 9 idle
    {6'b00_011_0, 32'h0000_1000, 4'h6},  // 10 target read address
    {6'b00_001_0, 32'h0000_0000, 4'h0},  // 11 wait
    {6'b00_000_1, 32'h1357_9BDF, 4'h0},  // 12 target read data
    {6'b00_100_1, 32'hFFFF_FFFF, 4'h0},  // 13 last target read data
    {6'b00_111_0, 32'h0000_0000, 4'hF},  // 14 idle
    {6'b01_011_0, 32'h0000_2000, 4'h7},  // 15 target write address
    {6'b01_100_0, 32'h5555_AAAA, 4'h1},  // 16 target write data
    {6'b01_111_0, 32'h0000_0000, 4'hF}   // 17 idle
  };

  function automatic string tag_of(int row);
    case (row)
      1, 6:     return "R3";
      3:        return "R4";
      4, 13:    return "R8";
      12:       return "R5";
      8, 16:    return "R6";
      2, 7, 11: return "R7";
      10, 15:   return "R9";
      default:  return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Drive one bus clock at the falling edge, then wait one full clock so
  // the registered outputs reflect that clock.
  task automatic step(logic m, logic w, logic f, logic i, logic t,
                      logic [31:0] a, logic [3:0] c);
    is_master = m; is_write = w; frame_n = f; irdy_n = i; trdy_n = t;
    ad = a; cbe_n = c;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", par_oe, 1'b0, "oe in reset");
    check("R1", par,    1'b0, "par in reset");
    rst = 1'b0;

    for (int k = 0; k < N; k++) begin
      logic exp_oe, exp_par;
      exp_oe  = TBL[k][36];
      exp_par = exp_oe & (^TBL[k][35:0]);
      step(TBL[k][41], TBL[k][40], TBL[k][39], TBL[k][38], TBL[k][37],
           TBL[k][35:4], TBL[k][3:0]);
      check(tag_of(k), par_oe, exp_oe, $sformatf("row %0d oe", k));
      check(exp_oe ? "R2" : "R10", par, exp_par, $sformatf("row %0d par", k));
    end

    // R2 corners: 36 ones gives parity 0, five ones gives parity 1.
    step(1, 1, 0, 1, 1, 32'hFFFF_FFFF, 4'hF);
    check("R2", par_oe, 1'b1, "all-ones address oe");
    check("R2", par,    1'b0, "all-ones address par");
    step(1, 1, 1, 0, 0, 32'h0000_0001, 4'hF);
    check("R2", par_oe, 1'b1, "sparse data oe");
    check("R2", par,    1'b1, "sparse data par");
    step(1, 1, 1, 1, 1, 32'h0, 4'hF);

    // R1: reset lands on a completing write data edge.
    step(1, 1, 0, 1, 1, 32'h0000_0007, 4'h7);
    rst = 1'b1;
    step(1, 1, 1, 0, 0, 32'h0000_0001, 4'h0);
    check("R1", par_oe, 1'b0, "oe after reset on completion");
    check("R1", par,    1'b0, "par after reset on completion");
    rst = 1'b0;
    step(1, 1, 1, 1, 1, 32'h0, 4'hF);
    check("R1", par_oe, 1'b0, "oe idle after reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule